// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands of a configurable width (32 bits by default) and returns the full double-width product. It takes one clock per multiplier bit and uses a single operand-width adder. A pulse on `start` while the block is idle captures both operands. The multiplier is placed in the low half of a double-width product register, and the upper half is cleared.

Each following clock inspects the least significant product bit. When that bit is set, the stored multiplicand is added to the upper half. In the same clock the whole register, extended by the adder's carry-out, shifts right by one place. After exactly `WIDTH` such clocks the block leaves its busy state and pulses `done` for one cycle. The register then holds the finished product, and it stays visible on `product` until the next accepted start.

The adder is a parameter-selected variant: either the synthesis operator or an explicit chain of full-adder cells. Both variants have the same cycle behaviour.

Top module: `seqmul_top`

## Requirements
- R1: While `rst` is high and after its release, `busy`, `done` and `product` are all zero until the first start is accepted.
- R2: A high `start` sampled on a clock edge while `busy` is low is accepted. After that edge `busy` is high and `product` equals the multiplier zero-extended to `2*WIDTH` bits.
- R3: `busy` stays high for exactly `WIDTH` clock edges after the accepting edge. On the `WIDTH`-th of those edges `busy` falls and `done` rises.
- R4: When `done` is high, `product` equals the exact unsigned product of the accepted operands. This includes operands whose partial sums carry out of the upper half, such as all ones times all ones.
- R5: `done` is high for one clock cycle only per multiply.
- R6: While idle with `start` low, `product` does not change, whatever values the operand inputs take.
- R7: `start` sampled while `busy` is high has no effect: neither the completion cycle nor the result changes.
- R8: A `start` presented in the cycle where `done` is high is accepted, and a new multiply begins back to back.
- R9: The operand inputs are used only on the accepting edge. Changing them during a multiply does not alter its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a multiply; honoured only while idle |
| multiplicand | input | WIDTH | First unsigned operand, captured on the accepting edge |
| multiplier | input | WIDTH | Second unsigned operand, captured on the accepting edge |
| busy | output | 1 | High while the iterations are in progress |
| done | output | 1 | One-cycle pulse marking a finished product |
| product | output | 2*WIDTH | Product register; the full result when `done` is high and held afterwards |

## Verification
The embedded properties watch the cycle-level protocol on every clock. They check that the operand load image is correct, that the run lasts while the step counter has not reached its end, that `done` is a single-cycle pulse that closes a run, that the register is stable when idle, and that the lower half shifts by one place on each step. They also check that the stored multiplicand stays constant until the next load and that a start during a run does not disturb the step count. Only the bench's scenarios can show that the arithmetic value is right, because that needs an independent double-width reference. Among those scenarios are carry-heavy all-ones operands, zero and unit operands, random pairs, operand and start noise during a run, and a back-to-back restart in the `done` cycle.

// File: rtl/seqmul_pkg.sv
package seqmul_pkg;
   typedef enum logic [0:0] {
      SM_IDLE = 1'b0,
      SM_RUN  = 1'b1
   } seqmul_state_e;

   localparam int unsigned ADDER_OPERATOR = 0;
   localparam int unsigned ADDER_RIPPLE   = 1;
endpackage

// File: rtl/seqmul_adder.sv
module seqmul_adder #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned STYLE = 0
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   output logic [WIDTH:0]   sum
);
   import seqmul_pkg::*;

   generate
      if (STYLE == ADDER_OPERATOR) begin : g_operator
         assign sum = {1'b0, op_a} + {1'b0, op_b};
      end else if (STYLE == ADDER_RIPPLE) begin : g_ripple
         logic [WIDTH:0]   carry;
         logic [WIDTH-1:0] bits;
         assign carry[0] = 1'b0;
         for (genvar i = 0; i < WIDTH; i++) begin : g_cell
            assign bits[i]    = op_a[i] ^ op_b[i] ^ carry[i];
            assign carry[i+1] = (op_a[i] & op_b[i]) | (op_a[i] & carry[i]) | (op_b[i] & carry[i]);
         end
         assign sum = {carry[WIDTH], bits};
      end else begin : g_bad_style
         $error("seqmul_adder: STYLE must be 0 or 1");
      end
   endgenerate
endmodule

// File: rtl/seqmul_ctrl.sv
module seqmul_ctrl #(
   parameter int unsigned WIDTH = 32
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   output logic load,
   output logic step,
   output logic busy,
   output logic done
);
   import seqmul_pkg::*;

   localparam int unsigned CW = $clog2(WIDTH + 1);
   localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

   seqmul_state_e state;
   logic [CW-1:0] iter;

   assign busy = (state == SM_RUN);
   assign load = (state == SM_IDLE) && start;
   assign step = (state == SM_RUN);

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= SM_IDLE;
         iter  <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            SM_IDLE: begin
               if (start) begin
                  state <= SM_RUN;
                  iter  <= '0;
               end
            end
            SM_RUN: begin
               if (iter == LAST) begin
                  state <= SM_IDLE;
                  done  <= 1'b1;
               end else begin
                  iter <= iter + 1'b1;
               end
            end
            default: state <= SM_IDLE;
         endcase
      end
   end

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R5
   AST_RUN_CONTINUES: assert property (@(posedge clk) disable iff (rst)
      (busy && iter != LAST) |=> busy); // R3
   AST_DONE_CLOSES_RUN: assert property (@(posedge clk) disable iff (rst)
      done |-> (!busy && $past(busy))); // R3
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
      (busy && start && iter != LAST) |=> (busy && iter == $past(iter) + 1'b1)); // R7
   AST_ITER_RANGE: assert property (@(posedge clk) disable iff (rst)
      busy |-> (iter <= LAST)); // R3
endmodule

// File: rtl/seqmul_dpath.sv
module seqmul_dpath #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned ADDER_STYLE = 0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               load,
   input  logic               step,
   input  logic [WIDTH-1:0]   mcand_in,
   input  logic [WIDTH-1:0]   mplier_in,
   output logic [2*WIDTH-1:0] prod
);
   localparam int unsigned PW = 2 * WIDTH;

   logic [WIDTH-1:0] mcand_q;
   logic [WIDTH-1:0] addend;
   logic [WIDTH:0]   upper_sum;
   logic [PW-1:0]    prod_next;

   assign addend = prod[0] ? mcand_q : '0;

   seqmul_adder #(
      .WIDTH (WIDTH),
      .STYLE (ADDER_STYLE)
   ) adder_i (
      .op_a (prod[PW-1:WIDTH]),
      .op_b (addend),
      .sum  (upper_sum)
   );

   assign prod_next = {upper_sum, prod[WIDTH-1:1]};

   always_ff @(posedge clk) begin
      if (rst) begin
         mcand_q <= '0;
         prod    <= '0;
      end else if (load) begin
         mcand_q <= mcand_in;
         prod    <= {{WIDTH{1'b0}}, mplier_in};
      end else if (step) begin
         prod    <= prod_next;
      end
   end

   AST_LOAD_IMAGE: assert property (@(posedge clk) disable iff (rst)
      load |=> (prod == {{WIDTH{1'b0}}, $past(mplier_in)})); // R2
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!load && !step) |=> $stable(prod)); // R6
   AST_LOW_SHIFT: assert property (@(posedge clk) disable iff (rst)
      step |=> (prod[WIDTH-2:0] == $past(prod[WIDTH-1:1]))); // R4
   AST_MCAND_KEPT: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(mcand_q)); // R9
endmodule

// File: rtl/seqmul_top.sv
module seqmul_top #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned ADDER_STYLE = 0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               start,
   input  logic [WIDTH-1:0]   multiplicand,
   input  logic [WIDTH-1:0]   multiplier,
   output logic               busy,
   output logic               done,
   output logic [2*WIDTH-1:0] product
);
   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("seqmul_top: WIDTH must be at least 2");
      end
   endgenerate

   logic load;
   logic step;

   seqmul_ctrl #(
      .WIDTH (WIDTH)
   ) ctrl_i (
      .clk   (clk),
      .rst   (rst),
      .start (start),
      .load  (load),
      .step  (step),
      .busy  (busy),
      .done  (done)
   );

   seqmul_dpath #(
      .WIDTH       (WIDTH),
      .ADDER_STYLE (ADDER_STYLE)
   ) dpath_i (
      .clk       (clk),
      .rst       (rst),
      .load      (load),
      .step      (step),
      .mcand_in  (multiplicand),
      .mplier_in (multiplier),
      .prod      (product)
   );

   AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (rst)
      (start && !busy) |=> busy); // R2
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
      done |-> !busy); // R8
endmodule

// File: tb/seqmul_top_tb_top.sv
module seqmul_top_tb_top;
   localparam int unsigned W = 32;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           start = 1'b0;
   logic [W-1:0]   mcand = '0;
   logic [W-1:0]   mplier = '0;
   logic           busy;
   logic           done;
   logic [2*W-1:0] product;

   int total = 0;
   int bad = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   seqmul_top #(
      .WIDTH       (W),
      .ADDER_STYLE (1)
   ) dut_i (
      .clk          (clk),
      .rst          (rst),
      .start        (start),
      .multiplicand (mcand),
      .multiplier   (mplier),
      .busy         (busy),
      .done         (done),
      .product      (product)
   );

   task automatic chk(input bit ok, input string tag, input logic [2*W-1:0] act,
                      input logic [2*W-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
      logic [2*W-1:0] ea, eb;
      ea = {{W{1'b0}}, a};
      eb = {{W{1'b0}}, b};
      return ea * eb;
   endfunction

   // Present start at a negedge; returns at the negedge after the accepting edge.
   task automatic start_op(input logic [W-1:0] a, input logic [W-1:0] b);
      start  = 1'b1;
      mcand  = a;
      mplier = b;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1, "R2 busy after accept", {63'b0, busy}, 64'd1);
      chk(product === {{W{1'b0}}, b}, "R2 load image", product, {{W{1'b0}}, b});
   endtask

   // Run the WIDTH step edges; returns at the negedge where done is expected.
   task automatic finish_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit noise);
      bit run_ok = 1'b1;
      logic [2*W-1:0] exp = ref_mul(a, b);
      for (int k = 1; k <= W; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (k < W) begin
            if (busy !== 1'b1 || done !== 1'b0) run_ok = 1'b0;
            if (noise) begin
               start  = 1'b1;
               mcand  = $urandom;
               mplier = $urandom;
            end
         end
      end
      start = 1'b0;
      chk(run_ok, "R3 busy held for run", 64'd0, 64'd0);
      if (noise) chk(run_ok, "R7 start during run ignored", 64'd0, 64'd0);
      chk(busy === 1'b0 && done === 1'b1, "R3 done timing", {62'b0, busy, done}, 64'd1);
      chk(product === exp, noise ? "R9 result with operand noise" : "R4 product value",
          product, exp);
   endtask

   task automatic after_done(input logic [W-1:0] a, input logic [W-1:0] b);
      logic [2*W-1:0] exp = ref_mul(a, b);
      mcand  = $urandom;
      mplier = $urandom;
      @(posedge clk);
      @(negedge clk);
      chk(done === 1'b0, "R5 done single cycle", {63'b0, done}, 64'd0);
      mcand  = $urandom;
      mplier = $urandom;
      @(posedge clk);
      @(negedge clk);
      chk(product === exp && busy === 1'b0, "R6 product held idle", product, exp);
   endtask

   task automatic do_mul(input logic [W-1:0] a, input logic [W-1:0] b);
      start_op(a, b);
      finish_op(a, b, 1'b0);
      after_done(a, b);
   endtask

   task automatic test_reset();
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(busy === 1'b0 && done === 1'b0 && product === '0, "R1 outputs in reset",
          product, 64'd0);
      rst = 1'b0;
      mcand  = 32'hdead_beef;
      mplier = 32'h1234_5678;
      @(posedge clk);
      @(negedge clk);
      chk(busy === 1'b0 && done === 1'b0 && product === '0, "R1 outputs after release",
          product, 64'd0);
   endtask

   task automatic test_corners();
      do_mul('0, '0);
      do_mul('0, '1);
      do_mul('1, '0);
      do_mul(32'd1, 32'hcafe_f00d);
      do_mul(32'h8765_4321, 32'd1);
      do_mul('1, '1);
      do_mul('1, 32'd1);
      do_mul(32'h8000_0000, 32'h8000_0000);
      do_mul(32'd8, 32'd9);
   endtask

   task automatic test_random();
      for (int n = 0; n < 12; n++) begin
         logic [W-1:0] a = $urandom;
         logic [W-1:0] b = $urandom;
         do_mul(a, b);
      end
   endtask

   task automatic test_noise();
      logic [W-1:0] a = 32'hffff_fffe;
      logic [W-1:0] b = 32'h7fff_ffff;
      start_op(a, b);
      finish_op(a, b, 1'b1);
      after_done(a, b);
   endtask

   task automatic test_back_to_back();
      logic [W-1:0] a1 = 32'h0001_0003;
      logic [W-1:0] b1 = 32'hffff_0000;
      logic [W-1:0] a2 = 32'h1357_9bdf;
      logic [W-1:0] b2 = 32'h2468_ace0;
      start_op(a1, b1);
      finish_op(a1, b1, 1'b0);
      // done is high now: restart in this very cycle
      start_op(a2, b2);
      chk(busy === 1'b1, "R8 restart in done cycle", {63'b0, busy}, 64'd1);
      finish_op(a2, b2, 1'b0);
      chk(product === ref_mul(a2, b2), "R8 second result", product, ref_mul(a2, b2));
      after_done(a2, b2);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 100000);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      test_reset();
      test_corners();
      test_random();
      test_noise();
      test_back_to_back();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule